// File: doc/BRIEF.md
# System control register interface

This block sits beside a CPU core and serves the coprocessor transfer instructions aimed at coprocessor number 15. Each cycle in which the core presents a valid 32-bit instruction word, the block decodes it. It checks that the access is allowed. It then either stores the core's write data into one of its control registers, or returns a register's contents for write-back into a core register. The stored registers are exported as plain outputs, where cache, tightly coupled memory and MMU control logic use them.

A primary register number can name more than one physical register. For numbers 0, 5 and 13 the secondary opcode field picks the register. For number 9 the CRm field picks it. The block raises an undefined-instruction exception in three cases: an access from user mode, a data-processing, load or store coprocessor operation addressed to it, and a transfer that names core register 15. Responses are registered and appear one cycle after the valid cycle.

Top module: `sysctl_cop`

## Requirements
- R1: While reset is held and after it is released, every writable register reads zero, and `undef_exc`, `rd_we` and `rd_data` are zero.
- R2: A privileged write transfer (bits[27:24]=1110, bit 4=1, bits[11:8]=1111, L bit 20=0) to an implemented writable register stores `wr_data`. The new value appears on that register's output port after the clock edge of the valid cycle.
- R3: A privileged read transfer (L=1) sets `rd_we` for exactly one cycle, on the cycle after the valid cycle, with the selected register in `rd_data`. `rd_data` is zero whenever `rd_we` is low.
- R4: Register 0 with secondary opcode (bits[7:5]) 0 reads the ID parameter, and with secondary opcode 1 reads the cache-type parameter. Writes to either are ignored.
- R5: For registers 5 and 13, secondary opcode 0 and 1 select two distinct physical registers (data fault status / instruction fault status; process ID / context ID).
- R6: For register 9, CRm (bits[3:0]) 0 selects the data lockdown register and CRm 1 selects the instruction lockdown register.
- R7: Any register number and selector combination that is not implemented reads as zero and ignores writes, without raising an exception. Registers 1, 2, 3 and 6 exist only with CRm=0 and secondary opcode 0.
- R8: A transfer issued with `priv` low asserts `undef_exc` for one cycle, returns no write-back and changes no register.
- R9: A data-processing operation (bits[27:24]=1110, bit 4=0) or a load/store operation (bits[27:25]=110) with coprocessor number 15 asserts `undef_exc` and changes nothing.
- R10: A transfer whose core register field (bits[15:12]) is 15 asserts `undef_exc` and performs no write or write-back.
- R11: An instruction with a coprocessor number other than 15, or any instruction while `instr_valid` is low, causes no exception, no write-back and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Coprocessor instruction word |
| priv | input | 1 | Core is in a privileged mode |
| wr_data | input | 32 | Core register value for write transfers |
| rd_data | output | 32 | Register value returned by a read transfer |
| rd_we | output | 1 | Write-back enable for the core register |
| undef_exc | output | 1 | Undefined-instruction exception, one cycle |
| ctrl_o | output | 32 | Main control register (reg 1) |
| ttb_o | output | 32 | Translation table base (reg 2) |
| dac_o | output | 32 | Domain access control (reg 3) |
| dfsr_o | output | 32 | Data fault status (reg 5, op2 0) |
| ifsr_o | output | 32 | Instruction fault status (reg 5, op2 1) |
| far_o | output | 32 | Fault address (reg 6) |
| dlock_o | output | 32 | Data cache lockdown (reg 9, CRm 0) |
| ilock_o | output | 32 | Instruction cache lockdown (reg 9, CRm 1) |
| pid_o | output | 32 | Process ID (reg 13, op2 0) |
| ctxid_o | output | 32 | Context ID (reg 13, op2 1) |

## Verification
The register bank is written and read back with a distinct data pattern per register. This shows that every selector routes to its own storage and not to a neighbour. Pairs that differ only in secondary opcode or only in CRm are written with different values and both read back, which separates the multiplexed registers from each other. Faulting patterns are user mode, data-processing, load/store and core register 15. Each is aimed at a register holding a known value, so a suppressed write can be told apart from one that took effect. A foreign coprocessor number and unimplemented selectors show that silent ignoring differs from faulting.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NPHYS = 12;
  localparam int IW    = $clog2(NPHYS);

  localparam logic [IW-1:0] P_ID    = IW'(0);
  localparam logic [IW-1:0] P_CTYPE = IW'(1);
  localparam logic [IW-1:0] P_CTRL  = IW'(2);
  localparam logic [IW-1:0] P_TTB   = IW'(3);
  localparam logic [IW-1:0] P_DAC   = IW'(4);
  localparam logic [IW-1:0] P_DFSR  = IW'(5);
  localparam logic [IW-1:0] P_IFSR  = IW'(6);
  localparam logic [IW-1:0] P_FAR   = IW'(7);
  localparam logic [IW-1:0] P_DLOCK = IW'(8);
  localparam logic [IW-1:0] P_ILOCK = IW'(9);
  localparam logic [IW-1:0] P_PID   = IW'(10);
  localparam logic [IW-1:0] P_CTXID = IW'(11);

  typedef struct packed {
    logic       ours;     // coprocessor number is 15
    logic       xfer;     // register transfer form
    logic       other_op; // data-processing or load/store form
    logic       load;     // L bit: 1 = read into core
    logic [3:0] crn;
    logic [3:0] core_reg;
    logic [3:0] crm;
    logic [2:0] op2;
  } insn_t;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
  } sel_t;

  function automatic insn_t decode_insn(input logic [31:0] w);
    insn_t d;
    d.ours     = (w[11:8] == 4'hF);
    d.xfer     = (w[27:24] == 4'b1110) &&  w[4];
    d.other_op = ((w[27:24] == 4'b1110) && !w[4]) || (w[27:25] == 3'b110);
    d.load     = w[20];
    d.crn      = w[19:16];
    d.core_reg = w[15:12];
    d.crm      = w[3:0];
    d.op2      = w[7:5];
    return d;
  endfunction

  function automatic sel_t map_phys(input logic [3:0] crn, input logic [3:0] crm,
                                    input logic [2:0] op2);
    sel_t s;
    logic plain;
    logic pair;
    plain = (crm == 4'd0) && (op2 == 3'd0);
    pair  = (crm == 4'd0) && (op2 <= 3'd1);
    s.hit = 1'b0;
    s.idx = P_ID;
    case (crn)
      4'd0:  begin s.hit = pair;  s.idx = op2[0] ? P_CTYPE : P_ID;   end
      4'd1:  begin s.hit = plain; s.idx = P_CTRL;                    end
      4'd2:  begin s.hit = plain; s.idx = P_TTB;                     end
      4'd3:  begin s.hit = plain; s.idx = P_DAC;                     end
      4'd5:  begin s.hit = pair;  s.idx = op2[0] ? P_IFSR : P_DFSR;  end
      4'd6:  begin s.hit = plain; s.idx = P_FAR;                     end
      4'd9:  begin
        s.hit = (op2 == 3'd0) && (crm <= 4'd1);
        s.idx = crm[0] ? P_ILOCK : P_DLOCK;
      end
      4'd13: begin s.hit = pair;  s.idx = op2[0] ? P_CTXID : P_PID;  end
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic is_writable(input logic [IW-1:0] idx);
    return (idx != P_ID) && (idx != P_CTYPE);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic          valid,
  input  logic [31:0]   instr,
  input  logic          priv,
  output logic          target,
  output logic          fault,
  output logic          do_wr,
  output logic          do_rd,
  output logic [IW-1:0] idx,
  output logic          hit
);
  insn_t d;
  sel_t  s;
  logic  legal;

  always_comb begin
    d      = decode_insn(instr);
    s      = map_phys(d.crn, d.crm, d.op2);
    target = valid && d.ours && (d.xfer || d.other_op);
    fault  = target && (!priv || !d.xfer || (d.core_reg == 4'd15));
    legal  = target && !fault;
    hit    = s.hit;
    idx    = s.idx;
    do_wr  = legal && !d.load && s.hit && is_writable(s.idx);
    do_rd  = legal &&  d.load;
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VAL   = 32'h5A01_0C13,
  parameter logic [31:0] CT_VAL   = 32'h1D15_2152
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] regs [NPHYS]
);
  for (genvar i = 0; i < NPHYS; i++) begin : g_reg
    if (IW'(i) == P_ID) begin : g_id
      assign regs[i] = DW'(ID_VAL);
    end else if (IW'(i) == P_CTYPE) begin : g_ct
      assign regs[i] = DW'(CT_VAL);
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                      q <= '0;
        else if (we && widx == IW'(i))   q <= wdata;
      end
      assign regs[i] = q;
    end
  end
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_pkg::*;
#(
  parameter int          DW     = 32,
  parameter logic [31:0] ID_VAL = 32'h5A01_0C13,
  parameter logic [31:0] CT_VAL = 32'h1D15_2152
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [31:0]   instr,
  input  logic          priv,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_we,
  output logic          undef_exc,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] ttb_o,
  output logic [DW-1:0] dac_o,
  output logic [DW-1:0] dfsr_o,
  output logic [DW-1:0] ifsr_o,
  output logic [DW-1:0] far_o,
  output logic [DW-1:0] dlock_o,
  output logic [DW-1:0] ilock_o,
  output logic [DW-1:0] pid_o,
  output logic [DW-1:0] ctxid_o
);
  logic          target, fault, do_wr, do_rd, hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] regs [NPHYS];

  sysctl_decode u_dec (
    .valid (instr_valid), .instr (instr), .priv (priv),
    .target(target), .fault(fault), .do_wr(do_wr), .do_rd(do_rd),
    .idx   (idx), .hit(hit)
  );

  sysctl_regbank #(.DW(DW), .ID_VAL(ID_VAL), .CT_VAL(CT_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(do_wr), .widx(idx), .wdata(wr_data),
    .regs(regs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_we     <= 1'b0;
      undef_exc <= 1'b0;
    end else begin
      undef_exc <= fault;
      rd_we     <= do_rd;
      rd_data   <= (do_rd && hit) ? regs[idx] : '0;
    end
  end

  assign ctrl_o  = regs[P_CTRL];
  assign ttb_o   = regs[P_TTB];
  assign dac_o   = regs[P_DAC];
  assign dfsr_o  = regs[P_DFSR];
  assign ifsr_o  = regs[P_IFSR];
  assign far_o   = regs[P_FAR];
  assign dlock_o = regs[P_DLOCK];
  assign ilock_o = regs[P_ILOCK];
  assign pid_o   = regs[P_PID];
  assign ctxid_o = regs[P_CTXID];
endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic          priv,
  input logic          target,
  input logic          fault,
  input logic          do_wr,
  input logic          undef_exc,
  input logic          rd_we,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] ctrl_o,
  input logic [DW-1:0] ttb_o
);
  // R3
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_we |-> rd_data == '0);

  // R8
  user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (target && !priv) |=> (undef_exc && !rd_we));

  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_exc && !fault) |=> !undef_exc);

  // R10
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(ctrl_o) && $stable(ttb_o)));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_wr |=> $stable(ctrl_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !target |=> (!undef_exc && !rd_we));

  // R1
  reset_flags_chk: assert property (@(posedge clk)
    !rst_n |=> (!undef_exc && !rd_we));

  // R3
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({undef_exc, rd_we}) <= 1);

  logic unused_ok;
  assign unused_ok = instr_valid;
endmodule

bind sysctl_cop sysctl_cop_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .priv(priv),
  .target(target), .fault(fault), .do_wr(do_wr), .undef_exc(undef_exc),
  .rd_we(rd_we), .rd_data(rd_data), .ctrl_o(ctrl_o), .ttb_o(ttb_o)
);

// File: tb/test_sysctl_cop.sv
module test_sysctl_cop;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_ID = 32'h5A01_0C13;
  localparam logic [31:0] EXP_CT = 32'h1D15_2152;

  logic clk = 0, rst_n = 0, instr_valid = 0, priv = 0;
  logic [31:0] instr = 0, wr_data = 0;
  logic [31:0] rd_data, ctrl_o, ttb_o, dac_o, dfsr_o, ifsr_o, far_o;
  logic [31:0] dlock_o, ilock_o, pid_o, ctxid_o;
  logic rd_we, undef_exc;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_cop i_sysctl_cop (.*);

  function automatic logic [31:0] xfer(input logic ld, input logic [3:0] crn,
      input logic [3:0] rd, input logic [3:0] crm, input logic [2:0] op2,
      input logic [3:0] cp = 4'hF);
    return {4'hE, 4'b1110, 3'b000, ld, crn, rd, cp, op2, 1'b1, crm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one instruction; returns after registered outputs settle
  task automatic issue(input logic [31:0] w, input logic p, input logic [31:0] d);
    @(negedge clk);
    instr = w; priv = p; wr_data = d; instr_valid = 1;
    @(negedge clk);
    instr_valid = 0; instr = 0; wr_data = 0;
  endtask

  task automatic wr(input logic [3:0] crn, input logic [3:0] crm,
                    input logic [2:0] op2, input logic [31:0] d);
    issue(xfer(0, crn, 4'd2, crm, op2), 1, d);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op2, input logic [31:0] exp);
    issue(xfer(1, crn, 4'd3, crm, op2), 1, 0);
    check({req, " rd_we"}, 32'(rd_we), 1);
    check({req, " rd_data"}, rd_data, exp);
    check({req, " no undef"}, 32'(undef_exc), 0);
    @(negedge clk);
    check({req, " rd_we one cycle"}, 32'(rd_we), 0);
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_o, 0); check("R1 ttb", ttb_o, 0);
    check("R1 ctxid", ctxid_o, 0); check("R1 rd_we", 32'(rd_we), 0);
    check("R1 undef", 32'(undef_exc), 0); check("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_basic();
    wr(4'd1, 0, 0, 32'h0000_1005);
    check("R2 ctrl_o", ctrl_o, 32'h0000_1005);
    wr(4'd2, 0, 0, 32'hA5A5_4000);
    check("R2 ttb_o", ttb_o, 32'hA5A5_4000);
    wr(4'd3, 0, 0, 32'h5555_FFFF);
    wr(4'd6, 0, 0, 32'hDEAD_BEEC);
    check("R2 far_o", far_o, 32'hDEAD_BEEC);
    rd_chk("R3 ctrl", 4'd1, 0, 0, 32'h0000_1005);
    rd_chk("R3 dac",  4'd3, 0, 0, 32'h5555_FFFF);
  endtask

  task automatic t_id();
    rd_chk("R4 id", 4'd0, 0, 0, EXP_ID);
    rd_chk("R4 ctype", 4'd0, 0, 3'd1, EXP_CT);
    wr(4'd0, 0, 0, 32'h1234_5678);
    wr(4'd0, 0, 3'd1, 32'h8765_4321);
    rd_chk("R4 id after write", 4'd0, 0, 0, EXP_ID);
    rd_chk("R4 ctype after write", 4'd0, 0, 3'd1, EXP_CT);
  endtask

  task automatic t_op2_sel();
    wr(4'd5, 0, 0, 32'h0000_00F1); wr(4'd5, 0, 3'd1, 32'h0000_00E2);
    wr(4'd13, 0, 0, 32'h0300_0000); wr(4'd13, 0, 3'd1, 32'h0000_0077);
    check("R5 dfsr", dfsr_o, 32'h0000_00F1); check("R5 ifsr", ifsr_o, 32'h0000_00E2);
    check("R5 pid", pid_o, 32'h0300_0000); check("R5 ctxid", ctxid_o, 32'h0000_0077);
    rd_chk("R5 rd ifsr", 4'd5, 0, 3'd1, 32'h0000_00E2);
    rd_chk("R5 rd pid", 4'd13, 0, 0, 32'h0300_0000);
  endtask

  task automatic t_crm_sel();
    wr(4'd9, 4'd0, 0, 32'h0000_000C); wr(4'd9, 4'd1, 0, 32'h0000_0003);
    check("R6 dlock", dlock_o, 32'h0000_000C); check("R6 ilock", ilock_o, 32'h0000_0003);
    rd_chk("R6 rd dlock", 4'd9, 4'd0, 0, 32'h0000_000C);
    rd_chk("R6 rd ilock", 4'd9, 4'd1, 0, 32'h0000_0003);
  endtask

  task automatic t_unimpl();
    rd_chk("R7 crn7", 4'd7, 0, 0, 0);
    rd_chk("R7 crn9 crm2", 4'd9, 4'd2, 0, 0);
    wr(4'd3, 4'd1, 0, 32'hFFFF_0000);          // CRm must be 0
    check("R7 dac kept", dac_o, 32'h5555_FFFF);
    wr(4'd1, 0, 3'd2, 32'hFFFF_FFFF);          // op2 must be 0
    check("R7 ctrl kept", ctrl_o, 32'h0000_1005);
    check("R7 no undef", 32'(undef_exc), 0);
  endtask

  task automatic t_user();
    issue(xfer(0, 4'd1, 4'd2, 0, 0), 0, 32'hFFFF_FFFF);
    check("R8 undef", 32'(undef_exc), 1);
    check("R8 ctrl kept", ctrl_o, 32'h0000_1005);
    @(negedge clk);
    check("R8 one cycle", 32'(undef_exc), 0);
    issue(xfer(1, 4'd2, 4'd2, 0, 0), 0, 0);
    check("R8 rd undef", 32'(undef_exc), 1);
    check("R8 rd no we", 32'(rd_we), 0);
  endtask

  task automatic t_other_ops();
    // data-processing: bit4=0, cp 15
    issue({4'hE, 4'b1110, 4'h0, 4'd1, 4'd2, 4'hF, 3'd0, 1'b0, 4'd0}, 1, 32'hFFFF_FFFF);
    check("R9 cdp undef", 32'(undef_exc), 1);
    check("R9 cdp ctrl kept", ctrl_o, 32'h0000_1005);
    // load/store: bits[27:25]=110, cp 15
    issue({4'hE, 3'b110, 5'b11001, 4'd1, 4'd2, 4'hF, 8'h00}, 1, 32'hFFFF_FFFF);
    check("R9 ldc undef", 32'(undef_exc), 1);
    check("R9 ldc no we", 32'(rd_we), 0);
  endtask

  task automatic t_r15();
    issue(xfer(0, 4'd1, 4'd15, 0, 0), 1, 32'hFFFF_FFFF);
    check("R10 undef", 32'(undef_exc), 1);
    check("R10 ctrl kept", ctrl_o, 32'h0000_1005);
    issue(xfer(1, 4'd1, 4'd15, 0, 0), 1, 0);
    check("R10 rd undef", 32'(undef_exc), 1);
    check("R10 rd no we", 32'(rd_we), 0);
  endtask

  task automatic t_foreign();
    issue(xfer(0, 4'd1, 4'd2, 0, 0, 4'hE), 1, 32'hFFFF_FFFF);
    check("R11 cp14 no undef", 32'(undef_exc), 0);
    check("R11 cp14 ctrl kept", ctrl_o, 32'h0000_1005);
    issue(xfer(1, 4'd1, 4'd2, 0, 0, 4'hE), 1, 0);
    check("R11 cp14 no we", 32'(rd_we), 0);
    @(negedge clk);
    instr = xfer(0, 4'd2, 4'd2, 0, 0); wr_data = 32'h0; priv = 1; instr_valid = 0;
    @(negedge clk);
    check("R11 invalid ttb kept", ttb_o, 32'hA5A5_4000);
    check("R11 invalid no we", 32'(rd_we), 0);
    instr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_id();
    t_op2_sel();
    t_crm_sel();
    t_unimpl();
    t_user();
    t_other_ops();
    t_r15();
    t_foreign();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule